// File: doc/BRIEF.md
# Dual-Format Serial Word Receiver

This block turns a single serial data line into parallel words. Each frame opens with a low start bit. Two format bits follow and choose the payload. A clear first format bit gives a 7-bit character. A set first format bit with a clear second one gives a 32-bit binary word. The payload arrives most significant bit first. An even parity bit and a high stop bit close the frame. A good frame appears on a 32-bit bus with a one-cycle valid strobe. Character payloads are zero-extended. A flag tells character words from binary words.

The block has two ways of timing bits, and a strap pin picks one while reset is held. In clocked transport, a bit is taken on each rising edge of an external serial clock. That clock is synchronised into the system clock domain first. In start-stop transport, the external clock is ignored. Each bit is then sampled at its centre, and the timing is counted in system clocks from the falling edge of the start bit. The bit period is `CLK_HZ/BAUD` cycles, and BAUD defaults to 9600.

The output side has no ready input and gives no back-pressure. Flow control belongs to the software at both ends. A consumer must take `rx_data` in the cycle in which `rx_valid` is high. The bus holds the last good word until the next one arrives. Parity errors, breaks and unsupported formats are reported as one-cycle pulses and never come with a valid strobe.

Top module: `dualfmt_serial_rx`

## Requirements
- R1: A frame is the start bit 0, FM1, FM2, N payload bits sent most significant bit first, a parity bit, and a stop bit. A good frame gives exactly one single-cycle `rx_valid` pulse, and `rx_data` carries the word in that same cycle.
- R2: FM1=0 selects N=7. `rx_data[6:0]` then holds the character, `rx_data[31:7]` is 0 and `rx_bin` is 0. FM1=1 with FM2=0 selects N=32, and `rx_bin` is 1.
- R3: Parity is even over FM1, FM2 and all N payload bits. A mismatch gives a one-cycle `rx_parity_err` pulse with no `rx_valid`.
- R4: A 0 in the stop position gives a one-cycle `rx_break` pulse, and the word is discarded with no `rx_valid`. Break takes precedence over a parity mismatch.
- R5: FM1=1 with FM2=1 gives a one-cycle `rx_format_err` pulse once FM2 is taken. The receiver then passes over 34 further bit periods (32 payload bits, parity and stop) with no other output, and the frame after that is received normally.
- R6: With the strap latched at 0 (clocked transport), a bit is taken from `sdin` at each rising edge of `sclk`. Each `sclk` phase must last at least 3 system clocks.
- R7: With the strap latched at 1 (start-stop transport), `sclk` has no effect. Bits are taken every `CLK_HZ/BAUD` system clocks, counted from the falling edge of the start bit. A low pulse that has gone before mid-bit is not taken as a start bit.
- R8: `mode_strap` is latched only while `rst` is high. A change on it during operation has no effect on the transport mode.
- R9: After reset, all outputs are 0. The four pulse outputs are never high in the same cycle, and each is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; `mode_strap` is latched while it is high |
| mode_strap | input | 1 | Transport select: 1 for start-stop, 0 for external serial clock |
| sclk | input | 1 | External serial clock (clocked transport only) |
| sdin | input | 1 | Serial data line, idle high |
| rx_data | output | 32 | Last good word (character payloads zero-extended) |
| rx_bin | output | 1 | 1 if the last good word was binary, 0 if it was a character |
| rx_valid | output | 1 | One-cycle strobe for a good word |
| rx_parity_err | output | 1 | One-cycle pulse on a parity mismatch |
| rx_break | output | 1 | One-cycle pulse when the stop bit is 0 |
| rx_format_err | output | 1 | One-cycle pulse for the unsupported FM1=FM2=1 format |

## Verification
The hardest case to reach from the ports is the format-error skip. It only shows up as correct when the frame after it is decoded properly. The stimulus therefore sends a 32-bit-length frame with both format bits set, and then at once a good frame. The monitor must see only the format-error pulse and then the good word.

Two other cases have no output of their own: a start glitch in start-stop transport, and a strap change without reset. For both, the stimulus applies the disturbance and then sends a frame in the latched transport. A missing or extra event then shows up in the scoreboard. During start-stop runs, a noise process keeps toggling `sclk`.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  localparam int CHAR_BITS = 7;
  localparam int BIN_BITS  = 32;
  // bit periods skipped after an unsupported format: payload + parity + stop
  localparam int SKIP_BITS = BIN_BITS + 2;

  typedef enum logic [2:0] {
    DF_IDLE, DF_FM1, DF_FM2, DF_DATA, DF_PAR, DF_STOP, DF_SKIP
  } dfr_state_t;

  typedef enum logic [1:0] {
    SM_HUNT, SM_CHK, SM_RUN
  } smp_state_t;
endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/serrx_bitclk.sv
module serrx_bitclk
  import serrx_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 9600
) (
  input  logic clk,
  input  logic rst,
  input  logic async_mode,
  input  logic sclk_s,
  input  logic din_s,
  input  logic frame_end,
  output logic bit_stb,
  output logic bit_val
);
  localparam int DIV  = CLK_HZ / BAUD;
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV + 1);

  smp_state_t    st;
  logic [CW-1:0] cnt;
  logic          sclk_d, din_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SM_HUNT;
      cnt     <= '0;
      bit_stb <= 1'b0;
      bit_val <= 1'b1;
      sclk_d  <= 1'b0;
      din_d   <= 1'b1;
    end else begin
      bit_stb <= 1'b0;
      sclk_d  <= sclk_s;
      din_d   <= din_s;
      if (!async_mode) begin
        st <= SM_HUNT;
        if (sclk_s && !sclk_d) begin
          bit_stb <= 1'b1;
          bit_val <= din_s;
        end
      end else begin
        unique case (st)
          SM_HUNT: if (din_d && !din_s) begin
            st  <= SM_CHK;
            cnt <= CW'(HALF - 1);
          end
          SM_CHK: if (cnt == '0) begin
            if (!din_s) begin
              bit_stb <= 1'b1;
              bit_val <= 1'b0;
              cnt     <= CW'(DIV - 1);
              st      <= SM_RUN;
            end else begin
              st <= SM_HUNT;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
          SM_RUN: if (frame_end) begin
            st <= SM_HUNT;
          end else if (cnt == '0) begin
            bit_stb <= 1'b1;
            bit_val <= din_s;
            cnt     <= CW'(DIV - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
          default: st <= SM_HUNT;
        endcase
      end
    end
  end

  assert_hunt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (async_mode && st == SM_HUNT) |=> !bit_stb);
  assert_clk_edge_only_R6: assert property (@(posedge clk) disable iff (rst)
    (!async_mode && !(sclk_s && !sclk_d)) |=> !bit_stb);
endmodule

// File: rtl/serrx_deframer.sv
module serrx_deframer
  import serrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bit_stb,
  input  logic        bit_val,
  output logic [31:0] data,
  output logic        bin,
  output logic        valid,
  output logic        perr,
  output logic        brk,
  output logic        fmt,
  output logic        frame_end
);
  dfr_state_t  st;
  logic        fm1, par;
  logic [5:0]  cnt;
  logic [31:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= DF_IDLE; fm1 <= 1'b0; par <= 1'b0; cnt <= '0; shreg <= '0;
      data <= '0; bin <= 1'b0; valid <= 1'b0; perr <= 1'b0;
      brk <= 1'b0; fmt <= 1'b0; frame_end <= 1'b0;
    end else begin
      valid <= 1'b0; perr <= 1'b0; brk <= 1'b0; fmt <= 1'b0; frame_end <= 1'b0;
      if (bit_stb) begin
        unique case (st)
          DF_IDLE: if (!bit_val) begin
            st <= DF_FM1; par <= 1'b0; shreg <= '0;
          end
          DF_FM1: begin
            fm1 <= bit_val; par <= bit_val; st <= DF_FM2;
          end
          DF_FM2: begin
            par <= par ^ bit_val;
            if (fm1 && bit_val) begin
              fmt <= 1'b1;
              cnt <= 6'(SKIP_BITS - 1);
              st  <= DF_SKIP;
            end else begin
              cnt <= fm1 ? 6'(BIN_BITS - 1) : 6'(CHAR_BITS - 1);
              st  <= DF_DATA;
            end
          end
          DF_DATA: begin
            shreg <= {shreg[30:0], bit_val};
            par   <= par ^ bit_val;
            if (cnt == '0) st <= DF_PAR;
            else cnt <= cnt - 1'b1;
          end
          DF_PAR: begin
            par <= par ^ bit_val; st <= DF_STOP;
          end
          DF_STOP: begin
            frame_end <= 1'b1;
            st        <= DF_IDLE;
            if (!bit_val) brk <= 1'b1;
            else if (par) perr <= 1'b1;
            else begin
              valid <= 1'b1; data <= shreg; bin <= fm1;
            end
          end
          DF_SKIP: if (cnt == '0) begin
            frame_end <= 1'b1; st <= DF_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
          default: st <= DF_IDLE;
        endcase
      end
    end
  end

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({valid, perr, brk, fmt}));
  assert_valid_single_R1: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  assert_char_zext_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && !bin) |-> (data[31:7] == '0));
  assert_break_stop0_R4: assert property (@(posedge clk) disable iff (rst)
    brk |-> $past(bit_stb && !bit_val && st == DF_STOP));
  assert_fmt_cause_R5: assert property (@(posedge clk) disable iff (rst)
    fmt |-> $past(bit_stb && bit_val && fm1 && st == DF_FM2));
endmodule

// File: rtl/dualfmt_serial_rx.sv
module dualfmt_serial_rx #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 9600
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mode_strap,
  input  logic        sclk,
  input  logic        sdin,
  output logic [31:0] rx_data,
  output logic        rx_bin,
  output logic        rx_valid,
  output logic        rx_parity_err,
  output logic        rx_break,
  output logic        rx_format_err
);
  logic       async_q;
  logic [1:0] sync_q;
  logic       bit_stb, bit_val, frame_end;

  // transport mode is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) async_q <= mode_strap;
  end

  serrx_sync #(.W(2)) u_sync (
    .clk(clk), .rst(rst), .d({sclk, sdin}), .q(sync_q)
  );

  serrx_bitclk #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_bitclk (
    .clk(clk), .rst(rst), .async_mode(async_q),
    .sclk_s(sync_q[1]), .din_s(sync_q[0]), .frame_end(frame_end),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  serrx_deframer u_dfr (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .data(rx_data), .bin(rx_bin), .valid(rx_valid), .perr(rx_parity_err),
    .brk(rx_break), .fmt(rx_format_err), .frame_end(frame_end)
  );

  assert_mode_fixed_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(async_q));
endmodule

// File: tb/dualfmt_serial_rx_test.sv
module dualfmt_serial_rx_test;
  localparam int CLK_HZ = 200_000_000;
  localparam int BAUD   = 12_500_000;
  localparam int DIV    = CLK_HZ / BAUD;

  logic clk = 1'b0, rst = 1'b1, mode_strap = 1'b1, sclk = 1'b0, sdin = 1'b1;
  logic [31:0] rx_data;
  logic rx_bin, rx_valid, rx_parity_err, rx_break, rx_format_err;

  dualfmt_serial_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
    .clk(clk), .rst(rst), .mode_strap(mode_strap), .sclk(sclk), .sdin(sdin),
    .rx_data(rx_data), .rx_bin(rx_bin), .rx_valid(rx_valid),
    .rx_parity_err(rx_parity_err), .rx_break(rx_break), .rx_format_err(rx_format_err)
  );

  always #2.5 clk = ~clk;

  typedef struct { int kind; logic [31:0] data; logic bin; string req; } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0, events = 0;
  bit async_tx = 1'b1, noise_en = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // sclk noise while in start-stop transport (must be ignored, R7)
  initial forever begin
    repeat (3) @(posedge clk);
    if (noise_en) sclk = ~sclk;
  end

  task automatic send_bit(input logic b);
    if (async_tx) begin
      sdin = b;
      repeat (DIV) @(posedge clk);
    end else begin
      sdin = b;
      repeat (4) @(posedge clk);
      sclk = 1'b1;
      repeat (4) @(posedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic idle(input int bits);
    sdin = 1'b1;
    repeat (bits * DIV) @(posedge clk);
  endtask

  task automatic send_frame(input logic fm1, input logic fm2, input logic [31:0] d,
                            input bit bad_par, input logic stop, input string req);
    int n;
    logic p;
    exp_t e;
    n = fm1 ? 32 : 7;
    p = fm1 ^ fm2 ^ bad_par;
    for (int i = 0; i < n; i++) p ^= d[i];
    e.req = req; e.data = '0; e.bin = 1'b0;
    if (fm1 && fm2) e.kind = 3;
    else if (!stop) e.kind = 2;
    else if (bad_par) e.kind = 1;
    else begin
      e.kind = 0;
      e.data = fm1 ? d : {25'd0, d[6:0]};
      e.bin = fm1;
    end
    q.push_back(e);
    send_bit(1'b0); send_bit(fm1); send_bit(fm2);
    for (int i = n - 1; i >= 0; i--) send_bit(d[i]);
    send_bit(p); send_bit(stop);
    idle(3);
  endtask

  task automatic do_reset(input logic strap);
    rst = 1'b1; mode_strap = strap; sdin = 1'b1; sclk = 1'b0;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  // scoreboard monitor
  int kind_now;
  logic [3:0] prev_pulse = '0;
  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0] pl;
      pl = {rx_format_err, rx_break, rx_parity_err, rx_valid};
      if ((pl & prev_pulse) != '0)
        chk(1'b0, "R9", "pulse longer than one cycle", pl, 0);
      if (pl != '0) begin
        events++;
        chk($onehot(pl), "R9", "pulses overlap", pl, 0);
        kind_now = rx_valid ? 0 : rx_parity_err ? 1 : rx_break ? 2 : 3;
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected event kind", kind_now, 99);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(kind_now == e.kind, e.req, "event kind", kind_now, e.kind);
          if (e.kind == 0) begin
            chk(rx_data == e.data, e.req, "rx_data", rx_data, e.data);
            chk(rx_bin == e.bin, e.req, "rx_bin", rx_bin, e.bin);
          end
        end
      end
      prev_pulse = pl;
    end else prev_pulse = '0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int ev0;
    // start-stop transport
    async_tx = 1'b1;
    do_reset(1'b1);
    @(negedge clk);
    chk({rx_data, rx_bin, rx_valid, rx_parity_err, rx_break, rx_format_err} == '0,
        "R9", "outputs after reset", {rx_data, rx_bin, rx_valid}, 0);
    noise_en = 1'b1;
    send_frame(1'b0, 1'b0, 32'h41, 1'b0, 1'b1, "R2");
    send_frame(1'b0, 1'b1, 32'h7F, 1'b0, 1'b1, "R2");
    send_frame(1'b1, 1'b0, 32'hDEADBEEF, 1'b0, 1'b1, "R1");
    send_frame(1'b1, 1'b0, 32'h00000001, 1'b1, 1'b1, "R3");
    send_frame(1'b0, 1'b0, 32'h55, 1'b1, 1'b1, "R3");
    send_frame(1'b1, 1'b0, 32'h12345678, 1'b0, 1'b0, "R4");
    send_frame(1'b0, 1'b0, 32'h2A, 1'b1, 1'b0, "R4");
    send_frame(1'b1, 1'b1, 32'hFFFF0000, 1'b0, 1'b1, "R5");
    send_frame(1'b1, 1'b0, 32'h80000000, 1'b0, 1'b1, "R5");
    // start glitch shorter than half a bit (R7)
    ev0 = events;
    sdin = 1'b0; repeat (3) @(posedge clk); sdin = 1'b1;
    idle(4);
    chk(events == ev0, "R7", "glitch produced event", events - ev0, 0);
    send_frame(1'b0, 1'b0, 32'h13, 1'b0, 1'b1, "R7");
    // strap change without reset has no effect (R8)
    mode_strap = 1'b0;
    send_frame(1'b1, 1'b0, 32'hA5A5C3C3, 1'b0, 1'b1, "R8");
    noise_en = 1'b0;
    sclk = 1'b0;

    // clocked transport
    async_tx = 1'b0;
    do_reset(1'b0);
    @(negedge clk);
    chk({rx_data, rx_bin, rx_valid} == '0, "R9", "outputs after second reset",
        {rx_data, rx_bin, rx_valid}, 0);
    send_frame(1'b0, 1'b0, 32'h5A, 1'b0, 1'b1, "R6");
    send_frame(1'b1, 1'b0, 32'h0F0F00FF, 1'b0, 1'b1, "R6");
    send_frame(1'b1, 1'b0, 32'h0, 1'b1, 1'b1, "R3");
    send_frame(1'b1, 1'b1, 32'h0, 1'b0, 1'b1, "R5");
    send_frame(1'b0, 1'b0, 32'h01, 1'b0, 1'b0, "R4");
    mode_strap = 1'b1;
    send_frame(1'b0, 1'b0, 32'h66, 1'b0, 1'b1, "R8");
    repeat (20) @(posedge clk);
    chk(q.size() == 0, "R1", "expected events left over", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule